// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block sits beside a processor's fetch path and decides when normal execution is interrupted. Each cycle it looks at seven request lines: system reset, machine check, instruction-storage fault (with four cause flags), data-storage fault, system call, external interrupt and decrementer. It picks the most urgent request that is allowed to run. On entry it redirects fetch to that class's vector. It also saves a return address in save register 0 and a filtered copy of the 32-bit machine state register, with cause flags, in save register 1. The machine state register is then updated for handler mode.

The same block executes the return-from-interrupt operation. That operation reloads the machine state register from save register 1 and redirects fetch to the address in save register 0. Software may write the machine state register directly. A machine check that arrives while machine checks are disabled puts the block into a checkstop condition, which only the reset input clears.

The sequencer has three states. RUN means no handler is active. HANDLER means a handler is running, and the block records the rank of the class being serviced. STOP is checkstop. The transitions are:
- RUN→HANDLER and HANDLER→HANDLER on an accepted entry.
- HANDLER→RUN and RUN→RUN on a return.
- RUN→STOP and HANDLER→STOP on a machine check while machine checks are disabled.
- STOP→RUN only through reset.

Top module: `trap_sequencer`

## Requirements
- R1: When several requests are eligible in the same cycle, exactly one is taken. The order, highest first, is system reset, machine check, instruction-storage fault, data-storage fault, system call, external, decrementer.
- R2: The redirect address on entry is the prefix ORed with a class offset. The offsets are reset 0x100, machine check 0x200, data-storage 0x300, instruction-storage 0x400, external 0x500, decrementer 0x900 and system call 0xC00. Address bits 7:0 of every vector are zero (256-byte slots).
- R3: The prefix is 0xFFF00000 when machine-state bit 25 (MSB-first numbering, so vector index 6) is 1. It is 0 otherwise.
- R4: External and decrementer requests are ignored while the interrupt-enable bit (MSB-first bit 16, vector index 15) is 0. Reset and machine check are never masked.
- R5: On entry, save register 1 receives the machine state ANDed with mask 0x87C0FFFF (MSB-first bits 0, 5–9, 16–31), ORed with the cause flags. For every class except instruction-storage, the cause flags are zero.
- R6: For an instruction-storage fault, cause input bit 3 sets MSB-first bit 1 of save register 1 (hashed translation miss). Cause bit 2 sets MSB-first bit 3 (direct-store segment). Cause bit 1 sets MSB-first bit 4 (protection). Cause bit 0 sets MSB-first bit 10 (segment table miss).
- R7: Save register 0 depends on the class. For reset, external and decrementer it receives the next-instruction address. For a system call it receives the current instruction address plus 4. For storage faults and machine check it receives the current instruction address.
- R8: On entry, machine-state bits PR (MSB-first 17), IR (26) and DR (27) are cleared, which is mask 0x00004030 in vector indexes. All other bits are kept. An entry overrides a software write in the same cycle.
- R9: While a handler runs, an ordered class (every class except reset and machine check) is taken only if it ranks above the class in service. Reset and machine check are taken at any time.
- R10: A machine check while the machine-check-enable bit (MSB-first bit 19, vector index 12) is 0 raises checkstop. Checkstop stays high and blocks all redirects, returns and writes until reset.
- R11: A return without a competing request redirects to save register 0 and copies save register 1 into the machine state register.
- R12: After reset, the machine state register and both save registers are zero, and redirect and checkstop are low.
- R13: A software write updates the machine state register when no entry or return happens in that cycle. Redirect stays low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address of the instruction now completing |
| nxt_pc | input | 32 | Address of the instruction that would run next |
| req_sreset | input | 1 | System reset request |
| req_mcheck | input | 1 | Machine check request |
| req_istore | input | 1 | Instruction-storage fault request |
| istore_cause | input | 4 | Instruction-storage fault cause flags |
| req_dstore | input | 1 | Data-storage fault request |
| req_syscall | input | 1 | System call request |
| req_extint | input | 1 | External interrupt request |
| req_decr | input | 1 | Decrementer request |
| rfi_en | input | 1 | Execute return-from-interrupt |
| msr_we | input | 1 | Software write strobe for the machine state register |
| msr_wdata | input | 32 | Software write data |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Save register 0 (return address) |
| srr1 | output | 32 | Save register 1 (saved state and cause) |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_addr | output | 32 | Fetch redirect target |
| checkstop | output | 1 | Checkstop condition |

## Verification
Every result is registered. A request, return or write sampled at one rising edge shows up after that same edge: redirect strobe, target, both save registers, the machine state register and checkstop all change then, and the redirect strobe drops one edge later. The bench drives inputs at the falling edge and queues the expected values for that step. A monitor compares them 2 ns after the following rising edge, so each comparison lands exactly one edge after its stimulus. Masked, out-ranked and checkstop cases also expect no redirect and unchanged registers in that same cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Class rank doubles as priority: lower value wins.
    typedef enum logic [2:0] {
        C_RST  = 3'd0,
        C_MCHK = 3'd1,
        C_ISF  = 3'd2,
        C_DSF  = 3'd3,
        C_SC   = 3'd4,
        C_EXT  = 3'd5,
        C_DEC  = 3'd6,
        C_NONE = 3'd7
    } exc_cls_t;

    localparam int NUM_CLS = 7;

    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_HANDLER = 2'd1,
        S_STOP    = 2'd2
    } seq_state_t;

    // Architectural bit n (MSB-first) sits at vector index 31-n.
    localparam int IDX_EE = 31 - 16;
    localparam int IDX_PR = 31 - 17;
    localparam int IDX_ME = 31 - 19;
    localparam int IDX_IP = 31 - 25;
    localparam int IDX_IR = 31 - 26;
    localparam int IDX_DR = 31 - 27;

    localparam int CAUSE_HASH = 31 - 1;
    localparam int CAUSE_DSEG = 31 - 3;
    localparam int CAUSE_PROT = 31 - 4;
    localparam int CAUSE_STAB = 31 - 10;

    localparam logic [31:0] SAVE_MASK  = 32'h87C0_FFFF;
    localparam logic [31:0] ENTRY_CLR  = (32'h1 << IDX_PR) | (32'h1 << IDX_IR) | (32'h1 << IDX_DR);

    function automatic logic [11:0] vec_offset(exc_cls_t c);
        logic [11:0] o;
        unique case (c)
            C_RST:   o = 12'h100;
            C_MCHK:  o = 12'h200;
            C_DSF:   o = 12'h300;
            C_ISF:   o = 12'h400;
            C_EXT:   o = 12'h500;
            C_DEC:   o = 12'h900;
            C_SC:    o = 12'hC00;
            default: o = 12'h000;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NUM = NUM_CLS
) (
    input  logic [NUM-1:0] req,
    input  logic           ee,
    input  exc_cls_t       active,
    output logic           hit,
    output exc_cls_t       pick
);

    logic [NUM-1:0] elig;

    for (genvar g = 0; g < NUM; g++) begin : g_elig
        localparam bit MASKABLE  = (g == int'(C_EXT)) || (g == int'(C_DEC));
        localparam bit UNORDERED = (g <= int'(C_MCHK));
        assign elig[g] = req[g]
                       & (!MASKABLE || ee)
                       & (UNORDERED || (g < int'(active)));
    end

    always_comb begin
        hit  = 1'b0;
        pick = C_NONE;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit  = 1'b1;
                pick = exc_cls_t'(3'(i));
            end
        end
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] HI_PREFIX = 32'hFFF0_0000,
    parameter int          CAUSE_W   = 4
) (
    input  exc_cls_t           cls,
    input  logic [31:0]        msr_in,
    input  logic [AW-1:0]      cur_pc,
    input  logic [AW-1:0]      nxt_pc,
    input  logic [CAUSE_W-1:0] isf_cause,
    output logic [AW-1:0]      vec_addr,
    output logic [AW-1:0]      save_pc,
    output logic [31:0]        save_state
);

    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    logic [31:0] cause;

    always_comb begin
        vec_addr = (msr_in[IDX_IP] ? AW'(HI_PREFIX) : '0) | AW'(vec_offset(cls));

        unique case (cls)
            C_RST, C_EXT, C_DEC: save_pc = nxt_pc;
            C_SC:                save_pc = cur_pc + INSN_BYTES;
            default:             save_pc = cur_pc;
        endcase

        cause = '0;
        if (cls == C_ISF) begin
            cause[CAUSE_HASH] = isf_cause[3];
            cause[CAUSE_DSEG] = isf_cause[2];
            cause[CAUSE_PROT] = isf_cause[1];
            cause[CAUSE_STAB] = isf_cause[0];
        end
        save_state = (msr_in & SAVE_MASK) | cause;
    end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] HI_PREFIX = 32'hFFF0_0000,
    parameter logic [31:0] MSR_INIT  = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] nxt_pc,
    input  logic          req_sreset,
    input  logic          req_mcheck,
    input  logic          req_istore,
    input  logic [3:0]    istore_cause,
    input  logic          req_dstore,
    input  logic          req_syscall,
    input  logic          req_extint,
    input  logic          req_decr,
    input  logic          rfi_en,
    input  logic          msr_we,
    input  logic [31:0]   msr_wdata,
    output logic [31:0]   msr,
    output logic [AW-1:0] srr0,
    output logic [31:0]   srr1,
    output logic          redir_valid,
    output logic [AW-1:0] redir_addr,
    output logic          checkstop
);

    seq_state_t state_q, state_nx;
    exc_cls_t   rank_q, active;
    logic [NUM_CLS-1:0] req_vec;
    logic       hit, stop_evt;
    exc_cls_t   pick;
    logic [AW-1:0] vec_addr, save_pc;
    logic [31:0]   save_state;

    // Bit index equals rank.
    assign req_vec = {req_decr, req_extint, req_syscall, req_dstore,
                      req_istore, req_mcheck, req_sreset};
    assign active  = (state_q == S_HANDLER) ? rank_q : C_NONE;

    trap_arbiter #(.NUM(NUM_CLS)) u_arb (
        .req    (req_vec),
        .ee     (msr[IDX_EE]),
        .active (active),
        .hit    (hit),
        .pick   (pick)
    );

    trap_vector #(.AW(AW), .HI_PREFIX(HI_PREFIX), .CAUSE_W(4)) u_vec (
        .cls        (pick),
        .msr_in     (msr),
        .cur_pc     (cur_pc),
        .nxt_pc     (nxt_pc),
        .isf_cause  (istore_cause),
        .vec_addr   (vec_addr),
        .save_pc    (save_pc),
        .save_state (save_state)
    );

    assign stop_evt = hit && (pick == C_MCHK) && !msr[IDX_ME];

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_RUN, S_HANDLER: begin
                if (stop_evt)    state_nx = S_STOP;
                else if (hit)    state_nx = S_HANDLER;
                else if (rfi_en) state_nx = S_RUN;
            end
            S_STOP:              state_nx = S_STOP;
            default:             state_nx = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msr         <= MSR_INIT;
            srr0        <= '0;
            srr1        <= '0;
            rank_q      <= C_NONE;
            redir_valid <= 1'b0;
            redir_addr  <= '0;
        end else begin
            redir_valid <= 1'b0;
            if (state_q != S_STOP && !stop_evt) begin
                if (hit) begin
                    redir_valid <= 1'b1;
                    redir_addr  <= vec_addr;
                    srr0        <= save_pc;
                    srr1        <= save_state;
                    msr         <= msr & ~ENTRY_CLR;
                    rank_q      <= pick;
                end else if (rfi_en) begin
                    redir_valid <= 1'b1;
                    redir_addr  <= srr0;
                    msr         <= srr1;
                    rank_q      <= C_NONE;
                end else if (msr_we) begin
                    msr         <= msr_wdata;
                end
            end
        end
    end

    assign checkstop = (state_q == S_STOP);

endmodule

// File: rtl/trap_seq_checker.sv
module trap_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_sreset,
    input logic        req_mcheck,
    input logic        req_istore,
    input logic        req_dstore,
    input logic        req_syscall,
    input logic        req_extint,
    input logic        req_decr,
    input logic        rfi_en,
    input logic [31:0] msr,
    input logic [31:0] srr0,
    input logic [31:0] srr1,
    input logic        redir_valid,
    input logic [31:0] redir_addr,
    input logic        checkstop
);

    logic any_req;
    assign any_req = req_sreset | req_mcheck | req_istore | req_dstore
                   | req_syscall | req_extint | req_decr;

    // R10: checkstop is sticky and silences redirects
    p_checkstop_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);
    p_checkstop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |-> !redir_valid);

    // R8: handler mode on entry
    p_entry_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !$past(rfi_en)) |-> (msr[14] == 1'b0 && msr[5] == 1'b0 && msr[4] == 1'b0));

    // R2: vectors land on slot boundaries
    p_vector_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !$past(rfi_en)) |-> (redir_addr[7:0] == 8'h00));

    // R3: prefix is one of two values
    p_vector_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !$past(rfi_en)) |-> (redir_addr[31:12] == 20'h0 || redir_addr[31:12] == 20'hFFF00));

    // R4: a lone external request with interrupts disabled does nothing
    p_masked_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_extint && !msr[15] && !req_sreset && !req_mcheck && !req_istore
         && !req_dstore && !req_syscall && !req_decr && !rfi_en) |=> !redir_valid);

    // R11: return restores state
    p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_en && !any_req && !checkstop) |=>
            (redir_valid && redir_addr == $past(srr0) && msr == $past(srr1)));

endmodule

bind trap_sequencer trap_seq_checker u_trap_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_sreset  (req_sreset),
    .req_mcheck  (req_mcheck),
    .req_istore  (req_istore),
    .req_dstore  (req_dstore),
    .req_syscall (req_syscall),
    .req_extint  (req_extint),
    .req_decr    (req_decr),
    .rfi_en      (rfi_en),
    .msr         (msr),
    .srr0        (srr0),
    .srr1        (srr1),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .checkstop   (checkstop)
);

// File: tb/test_trap_sequencer.sv
`timescale 1ns/1ps
module test_trap_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, nxt_pc = '0;
    logic        req_sreset = 0, req_mcheck = 0, req_istore = 0, req_dstore = 0;
    logic        req_syscall = 0, req_extint = 0, req_decr = 0;
    logic [3:0]  istore_cause = '0;
    logic        rfi_en = 0, msr_we = 0;
    logic [31:0] msr_wdata = '0;
    logic [31:0] msr, srr0, srr1, redir_addr;
    logic        redir_valid, checkstop;

    always #5 clk = ~clk;

    trap_sequencer i_trap_sequencer (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .req_sreset(req_sreset), .req_mcheck(req_mcheck), .req_istore(req_istore),
        .istore_cause(istore_cause), .req_dstore(req_dstore), .req_syscall(req_syscall),
        .req_extint(req_extint), .req_decr(req_decr), .rfi_en(rfi_en),
        .msr_we(msr_we), .msr_wdata(msr_wdata), .msr(msr), .srr0(srr0), .srr1(srr1),
        .redir_valid(redir_valid), .redir_addr(redir_addr), .checkstop(checkstop)
    );

    typedef struct {
        string       tag;
        logic        v;
        logic [31:0] a;
        logic [31:0] m;
        logic [31:0] s0;
        logic [31:0] s1;
        logic        cs;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0;
    bit   done = 0;

    // Bench model of architected state, maintained from the requirements.
    logic [31:0] bm_msr, bm_srr0, bm_srr1;
    logic        bm_cs;

    localparam logic [31:0] KEEP = 32'h87C0_FFFF;
    localparam logic [31:0] CLR  = 32'h0000_4030;

    function automatic logic [31:0] sv1(logic [31:0] m, logic [31:0] c);
        return (m & KEEP) | c;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares one expected item per driven step
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "redir_valid", 32'(redir_valid), 32'(e.v));
                if (e.v) chk(e.tag, "redir_addr", redir_addr, e.a);
                chk(e.tag, "msr", msr, e.m);
                chk(e.tag, "srr0", srr0, e.s0);
                chk(e.tag, "srr1", srr1, e.s1);
                chk(e.tag, "checkstop", 32'(checkstop), 32'(e.cs));
            end
        end
    end

    // driver: apply one cycle of stimulus and queue what must follow it
    task automatic step(string tag, logic [6:0] r, logic [3:0] cause, logic rfi,
                        logic we, logic [31:0] wd, logic [31:0] cp, logic [31:0] np,
                        logic ev, logic [31:0] ea);
        exp_t e;
        @(negedge clk);
        {req_decr, req_extint, req_syscall, req_dstore, req_istore, req_mcheck, req_sreset} = r;
        istore_cause = cause;
        rfi_en = rfi; msr_we = we; msr_wdata = wd; cur_pc = cp; nxt_pc = np;
        e.tag = tag; e.v = ev; e.a = ea; e.m = bm_msr;
        e.s0 = bm_srr0; e.s1 = bm_srr1; e.cs = bm_cs;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 7'b0, 4'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {req_decr, req_extint, req_syscall, req_dstore, req_istore, req_mcheck, req_sreset} = '0;
        rfi_en = 0; msr_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bm_msr = 0; bm_srr0 = 0; bm_srr1 = 0; bm_cs = 0;
    endtask

    // request bit order: [0] reset [1] mcheck [2] istore [3] dstore [4] syscall [5] ext [6] dec
    initial begin
        do_reset();
        idle("R12 reset state");

        // R13: software write
        bm_msr = 32'hC000_C030;
        step("R13 write", 7'b0, 4'b0, 0, 1, 32'hC000_C030, 0, 0, 0, 0);

        // R2 R4 R5 R7 R8: external entry
        bm_srr0 = 32'h2008; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R7 R8 ext entry", 7'b010_0000, 4'b0, 0, 0, 0, 32'h2000, 32'h2008, 1, 32'h500);

        // R11: return
        bm_msr = bm_srr1;
        step("R11 return", 7'b0, 4'b0, 1, 0, 0, 0, 0, 1, 32'h2008);

        // decrementer entry
        bm_srr0 = 32'h2104; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R2 dec entry", 7'b100_0000, 4'b0, 0, 0, 0, 32'h2100, 32'h2104, 1, 32'h900);

        // R9: external outranks decrementer in service
        bm_srr0 = 32'h2204; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R9 nest ext", 7'b010_0000, 4'b0, 0, 0, 0, 32'h2200, 32'h2204, 1, 32'h500);

        // R9: decrementer does not preempt external
        step("R9 dec blocked", 7'b100_0000, 4'b0, 0, 0, 0, 32'h2300, 32'h2304, 0, 0);

        // R7 R8 R13: syscall entry wins over a same-cycle write
        bm_srr0 = 32'h3004; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R13 R7 syscall", 7'b001_0000, 4'b0, 0, 1, 32'hFFFF_FFFF, 32'h3000, 32'h3010, 1, 32'hC00);

        bm_msr = bm_srr1;
        step("R11 return2", 7'b0, 4'b0, 1, 0, 0, 0, 0, 1, 32'h3004);

        // prefix high, interrupts disabled, machine checks enabled
        bm_msr = 32'h0000_1040;
        step("R13 write2", 7'b0, 4'b0, 0, 1, 32'h0000_1040, 0, 0, 0, 0);
        step("R4 ext masked", 7'b010_0000, 4'b0, 0, 0, 0, 32'h3100, 32'h3104, 0, 0);
        step("R4 dec masked", 7'b100_0000, 4'b0, 0, 0, 0, 32'h3100, 32'h3104, 0, 0);

        // R1 R3 R6: istore wins over dstore and syscall
        bm_srr0 = 32'h4000; bm_srr1 = sv1(bm_msr, 32'h4820_0000); bm_msr = bm_msr & ~CLR;
        step("R1 R3 R6 istore", 7'b001_1100, 4'b1011, 0, 0, 0, 32'h4000, 32'h4004, 1, 32'hFFF0_0400);

        bm_msr = bm_srr1;
        step("R11 return3", 7'b0, 4'b0, 1, 0, 0, 0, 0, 1, 32'h4000);

        bm_msr = 32'h0000_1040;
        step("R13 write3", 7'b0, 4'b0, 0, 1, 32'h0000_1040, 0, 0, 0, 0);

        // R1 R5: dstore beats syscall, cause bits zero
        bm_srr0 = 32'h5000; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R1 R5 dstore", 7'b001_1000, 4'b1111, 0, 0, 0, 32'h5000, 32'h5004, 1, 32'hFFF0_0300);

        // R9: reset preempts at any time
        bm_srr0 = 32'h5104; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R9 sreset", 7'b000_0001, 4'b0, 0, 0, 0, 32'h5100, 32'h5104, 1, 32'hFFF0_0100);

        // R9 R7: machine check taken while reset handler runs
        bm_srr0 = 32'h6000; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R9 mcheck", 7'b000_0010, 4'b0, 0, 0, 0, 32'h6000, 32'h6004, 1, 32'hFFF0_0200);

        // disable machine checks, then R10 checkstop
        bm_msr = 32'h0000_0040;
        step("R13 write4", 7'b0, 4'b0, 0, 1, 32'h0000_0040, 0, 0, 0, 0);
        bm_cs = 1;
        step("R10 checkstop", 7'b000_0010, 4'b0, 0, 0, 0, 32'h7000, 32'h7004, 0, 0);
        step("R10 held", 7'b001_0000, 4'b0, 1, 1, 32'h1234_5678, 32'h7100, 32'h7104, 0, 0);
        idle("R10 held2");

        do_reset();
        idle("R12 after reset");

        bm_srr0 = 32'h7004; bm_srr1 = sv1(bm_msr, 0); bm_msr = bm_msr & ~CLR;
        step("R3 R4 sreset low prefix", 7'b000_0001, 4'b0, 0, 0, 0, 32'h7000, 32'h7004, 1, 32'h100);
        idle("R1 quiet");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule